// File: doc/BRIEF.md
# Redundant Channel Voter and Reconfigurator

This block sits at the output of a set of replicated processing channels (one to four, fixed at build time). In every cycle that carries a vote, each channel presents one output word together with a flag that says whether its own local checks found an error. The block votes over the channels that are currently in service. It then either presents one consolidated word or raises a request to drive the system into its safe state.

How the vote works depends on how many channels are in service. With three or four, a single bad channel is outvoted and taken out of service. With two, the outputs must agree exactly. With one, the word passes through unless that channel flags an error. A build parameter sets the policy for a local error in two-channel operation: either go safe at once, or drop the flagged channel and carry on with the other one.

A channel taken out of service is asked to run a self-test. A test result of "temporary" returns it to service. A result of "permanent" parks it until an external repair acknowledge arrives. The safe request is sticky until reset.

Top module: `chv_top`

## Requirements
- R1: With three or more channels in service, a word agreed by more than half of the in-service count is output with out_valid high one cycle after the vote. Every in-service channel that disagreed with that word or flagged an error leaves service.
- R2: With exactly two channels in service and no local error flag, equal words are output. Unequal words raise safe_req one cycle after the vote, under both policies.
- R3: After reset, all NCH channels are in service and act_count equals NCH. act_count never reaches 0. It falls by at most one per vote.
- R4: Per-channel status is 2 bits: 0 = in service, 1 = under self-test (st_req high), 2 = awaiting repair. A channel leaving service goes to 1. From 1, st_done with st_perm high goes to 2, and st_done with st_perm low goes to 0. From 2, repair_ack goes to 0. A status holds otherwise.
- R5: With POLICY = fail-safe (0), a local error flag from either of two in-service channels raises safe_req.
- R6: With POLICY = degrade (1), a local error from exactly one of two in-service channels removes that channel and outputs the other channel's word. A mismatch with no flag still raises safe_req.
- R7: A word whose channel flags a local error in a cycle takes no part in that cycle's vote.
- R8: safe_req, once high, stays high until reset. While safe_req is high, out_valid is low and the pool is not changed by voting.
- R9: When the in-service channels hold no word agreed by more than half of them, safe_req is raised.
- R10: A channel returning to service at a clock edge is counted only from the next vote onward.
- R11: A cycle with in_valid low performs no vote. out_valid is low after it, and no channel leaves service.
- R12: With one channel in service, a local error flag raises safe_req and act_count stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Channel words are present; perform a vote |
| ch_word | input | NCH*W | Channel words, channel i at bits [i*W +: W] |
| ch_err | input | NCH | Local error flag per channel |
| st_done | input | NCH | Self-test finished, per channel |
| st_perm | input | NCH | Self-test verdict: 1 = permanent, 0 = temporary |
| repair_ack | input | NCH | Repair completed, per channel |
| out_valid | output | 1 | Consolidated word valid |
| out_word | output | W | Consolidated word |
| safe_req | output | 1 | Sticky safe-state request |
| st_req | output | NCH | Self-test request per channel |
| act_mask | output | NCH | In-service channel mask |
| act_count | output | clog2(NCH+1) | Number of in-service channels |
| ch_status | output | 2*NCH | Status per channel, channel i at bits [2i +: 2] |

## Verification
The embedded properties watch several things on every cycle. They check that the safe request never drops and never coexists with a valid output. They check that the in-service count never reaches zero and never falls by more than one per vote. They check that an idle cycle produces no valid output, and that the self-test and repair states are entered and left only through their handshakes. Only the bench scenarios can show which word wins a vote, that flagged words are excluded, and how the two policies diverge on a local error in two-channel operation. They also show no-majority detection and the cycle in which a returning channel first takes part. The bench covers these by comparing both policy builds against a behavioural reference on every clock, under directed and random stimulus.

// File: rtl/chv_pkg.sv
package chv_pkg;

    // Per-channel service state, as seen on ch_status
    typedef enum logic [1:0] {
        CS_ACTIVE = 2'd0,
        CS_TEST   = 2'd1,
        CS_REPAIR = 2'd2
    } chan_state_t;

    // Reaction to a local error while two channels remain
    typedef enum logic {
        POL_FAILSAFE = 1'b0,
        POL_DEGRADE  = 1'b1
    } policy_t;

    // Voting regime chosen from the in-service count
    typedef enum logic [1:0] {
        VM_NONE = 2'd0,
        VM_SOLO = 2'd1,
        VM_PAIR = 2'd2,
        VM_MAJ  = 2'd3
    } vote_mode_t;

    // Outcome of one vote
    typedef struct packed {
        logic ok;
        logic fail;
    } verdict_t;

    function automatic vote_mode_t mode_of(input int n_act);
        if (n_act >= 3)      return VM_MAJ;
        else if (n_act == 2) return VM_PAIR;
        else if (n_act == 1) return VM_SOLO;
        else                 return VM_NONE;
    endfunction

endpackage

// File: rtl/chv_vote.sv
module chv_vote
    import chv_pkg::*;
#(
    parameter int      NCH    = 4,
    parameter int      W      = 16,
    parameter policy_t POLICY = POL_FAILSAFE
) (
    input  logic [NCH-1:0]        active,
    input  logic [NCH-1:0]        err,
    input  logic [NCH-1:0][W-1:0] words,
    output verdict_t              verdict,
    output logic [W-1:0]          word,
    output logic [NCH-1:0]        drop
);

    logic [NCH-1:0] part;
    int             n_act;
    int             n_err;
    int             agree;
    logic           found;
    logic [W-1:0]   maj_word;
    logic [W-1:0]   solo_word;
    vote_mode_t     mode;

    // Find a word held by more than half of the in-service channels,
    // counting only channels without a local error flag
    always_comb begin
        part      = active & ~err;
        n_act     = $countones(active);
        n_err     = $countones(active & err);
        mode      = mode_of(n_act);
        found     = 1'b0;
        maj_word  = '0;
        solo_word = '0;
        agree     = 0;
        for (int i = 0; i < NCH; i++) begin
            agree = 0;
            for (int j = 0; j < NCH; j++) begin
                if (part[j] && (words[j] == words[i])) agree = agree + 1;
            end
            if (part[i] && !found && (2 * agree > n_act)) begin
                found    = 1'b1;
                maj_word = words[i];
            end
            if (part[i]) solo_word = words[i];
        end
    end

    // Verdict and channels to take out of service
    always_comb begin
        verdict = '0;
        word    = '0;
        drop    = '0;
        if (mode == VM_PAIR && n_err > 0) begin
            if (POLICY == POL_DEGRADE && n_err == 1) begin
                verdict.ok = 1'b1;
                word       = solo_word;
                drop       = active & err;
            end else begin
                verdict.fail = 1'b1;
            end
        end else if (found) begin
            verdict.ok = 1'b1;
            word       = maj_word;
            for (int i = 0; i < NCH; i++) begin
                drop[i] = active[i] & (err[i] | (words[i] != maj_word));
            end
        end else begin
            verdict.fail = 1'b1;
        end
    end

endmodule

// File: rtl/chv_slot.sv
module chv_slot
    import chv_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        drop,
    input  logic        st_done,
    input  logic        st_perm,
    input  logic        repair_ack,
    output chan_state_t state
);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= CS_ACTIVE;
        end else begin
            case (state)
                CS_ACTIVE: if (drop)       state <= CS_TEST;
                CS_TEST:   if (st_done)    state <= st_perm ? CS_REPAIR : CS_ACTIVE;
                CS_REPAIR: if (repair_ack) state <= CS_ACTIVE;
                default:                   state <= CS_ACTIVE;
            endcase
        end
    end

    AST_TEST_HOLD: assert property (@(posedge clk) disable iff (rst)
        (state == CS_TEST && !st_done) |=> (state == CS_TEST)); // R4

    AST_REPAIR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (state == CS_REPAIR && !repair_ack) |=> (state == CS_REPAIR)); // R4

    AST_PERM_PARKS: assert property (@(posedge clk) disable iff (rst)
        (state == CS_TEST && st_done && st_perm) |=> (state == CS_REPAIR)); // R4

endmodule

// File: rtl/chv_consol.sv
module chv_consol
    import chv_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         fire,
    input  verdict_t     verdict,
    input  logic [W-1:0] word,
    output logic         safe,
    output logic         out_valid,
    output logic [W-1:0] out_word
);

    always_ff @(posedge clk) begin
        if (rst) begin
            safe      <= 1'b0;
            out_valid <= 1'b0;
            out_word  <= '0;
        end else begin
            if (fire && verdict.fail) safe <= 1'b1;
            out_valid <= fire && verdict.ok;
            if (fire && verdict.ok) out_word <= word;
        end
    end

    AST_SAFE_STICKY: assert property (@(posedge clk) disable iff (rst)
        safe |=> safe); // R8

    AST_SAFE_QUIET: assert property (@(posedge clk) disable iff (rst)
        safe |-> !out_valid); // R8

endmodule

// File: rtl/chv_top.sv
module chv_top
    import chv_pkg::*;
#(
    parameter int      NCH    = 4,
    parameter int      W      = 16,
    parameter policy_t POLICY = POL_FAILSAFE,
    localparam int     CW     = $clog2(NCH + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [NCH*W-1:0]   ch_word,
    input  logic [NCH-1:0]     ch_err,
    input  logic [NCH-1:0]     st_done,
    input  logic [NCH-1:0]     st_perm,
    input  logic [NCH-1:0]     repair_ack,
    output logic               out_valid,
    output logic [W-1:0]       out_word,
    output logic               safe_req,
    output logic [NCH-1:0]     st_req,
    output logic [NCH-1:0]     act_mask,
    output logic [CW-1:0]      act_count,
    output logic [2*NCH-1:0]   ch_status
);

    logic [NCH-1:0][W-1:0] words;
    verdict_t              verdict;
    logic [W-1:0]          vote_word;
    logic [NCH-1:0]        vote_drop;
    logic [NCH-1:0]        leave;
    logic                  fire;
    chan_state_t           st_q [NCH];

    assign words = ch_word;
    assign fire  = in_valid & ~safe_req;
    assign leave = vote_drop & {NCH{fire & verdict.ok}};

    chv_vote #(.NCH(NCH), .W(W), .POLICY(POLICY)) u_vote (
        .active  (act_mask),
        .err     (ch_err),
        .words   (words),
        .verdict (verdict),
        .word    (vote_word),
        .drop    (vote_drop)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        chv_slot u_slot (
            .clk        (clk),
            .rst        (rst),
            .drop       (leave[g]),
            .st_done    (st_done[g]),
            .st_perm    (st_perm[g]),
            .repair_ack (repair_ack[g]),
            .state      (st_q[g])
        );
        assign act_mask[g]         = (st_q[g] == CS_ACTIVE);
        assign st_req[g]           = (st_q[g] == CS_TEST);
        assign ch_status[2*g +: 2] = st_q[g];
    end

    assign act_count = CW'($countones(act_mask));

    chv_consol #(.W(W)) u_consol (
        .clk       (clk),
        .rst       (rst),
        .fire      (fire),
        .verdict   (verdict),
        .word      (vote_word),
        .safe      (safe_req),
        .out_valid (out_valid),
        .out_word  (out_word)
    );

    AST_COUNT_FLOOR: assert property (@(posedge clk) disable iff (rst)
        act_count != '0); // R3

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        $past(act_count) <= act_count + 1'b1); // R3

    AST_IDLE_NO_OUT: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid); // R11

    AST_SOLO_ERR_SAFE: assert property (@(posedge clk) disable iff (rst)
        (in_valid && act_count == CW'(1) && |(act_mask & ch_err)) |=> safe_req); // R12

endmodule

// File: tb/chv_top_test.sv
`timescale 1ns/1ps
module chv_top_test;
    import chv_pkg::*;

    localparam int NCH = 4;
    localparam int W   = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic           iv_r = 1'b0;
    logic [W-1:0]   w_r [NCH];
    logic [NCH-1:0] e_r = '0, sd_r = '0, sp_r = '0, ra_r = '0;
    logic [NCH*W-1:0] ch_word;
    assign ch_word = {w_r[3], w_r[2], w_r[1], w_r[0]};

    logic           ov0, ov1, sf0, sf1;
    logic [W-1:0]   ow0, ow1;
    logic [NCH-1:0] rq0, rq1, mk0, mk1;
    logic [2:0]     ct0, ct1;
    logic [7:0]     cs0, cs1;

    chv_top #(.NCH(NCH), .W(W), .POLICY(POL_FAILSAFE)) uut (
        .clk(clk), .rst(rst), .in_valid(iv_r), .ch_word(ch_word), .ch_err(e_r),
        .st_done(sd_r), .st_perm(sp_r), .repair_ack(ra_r),
        .out_valid(ov0), .out_word(ow0), .safe_req(sf0), .st_req(rq0),
        .act_mask(mk0), .act_count(ct0), .ch_status(cs0));

    chv_top #(.NCH(NCH), .W(W), .POLICY(POL_DEGRADE)) uut_dg (
        .clk(clk), .rst(rst), .in_valid(iv_r), .ch_word(ch_word), .ch_err(e_r),
        .st_done(sd_r), .st_perm(sp_r), .repair_ack(ra_r),
        .out_valid(ov1), .out_word(ow1), .safe_req(sf1), .st_req(rq1),
        .act_mask(mk1), .act_count(ct1), .ch_status(cs1));

    int    checks = 0;
    int    errors = 0;
    string cur_tag = "R3";
    bit    armed = 1'b0;

    // Reference state: index 0 = fail-safe build, 1 = degrade build
    int           mst [2][NCH];
    bit           msf [2];
    bit           mov [2];
    logic [W-1:0] mow [2];

    task automatic chk(input bit good, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!good) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int p = 0; p < 2; p++) begin
            for (int i = 0; i < NCH; i++) mst[p][i] = 0;
            msf[p] = 1'b0;
            mov[p] = 1'b0;
            mow[p] = '0;
        end
    endtask

    task automatic model_step(input int p);
        int n, nerr, midx, c;
        bit ok, fl, act;
        logic [W-1:0] wd;
        bit [NCH-1:0] drp;
        n = 0; nerr = 0; midx = -1; ok = 0; fl = 0; wd = '0; drp = '0;
        for (int i = 0; i < NCH; i++) begin
            if (mst[p][i] == 0) begin
                n++;
                if (e_r[i]) nerr++;
            end
        end
        if (iv_r && !msf[p]) begin
            for (int i = 0; i < NCH; i++) begin
                if (mst[p][i] == 0 && !e_r[i]) begin
                    c = 0;
                    for (int j = 0; j < NCH; j++)
                        if (mst[p][j] == 0 && !e_r[j] && w_r[j] == w_r[i]) c++;
                    if (2 * c > n && midx < 0) midx = i;
                end
            end
            if (n == 2 && nerr > 0) begin
                if (p == 1 && nerr == 1) begin
                    ok = 1;
                    for (int i = 0; i < NCH; i++) begin
                        act = (mst[p][i] == 0);
                        if (act && !e_r[i]) wd = w_r[i];
                        if (act && e_r[i]) drp[i] = 1'b1;
                    end
                end else fl = 1;
            end else if (midx >= 0) begin
                ok = 1;
                wd = w_r[midx];
                for (int i = 0; i < NCH; i++)
                    if (mst[p][i] == 0 && (e_r[i] || w_r[i] != wd)) drp[i] = 1'b1;
            end else fl = 1;
        end
        if (fl) msf[p] = 1'b1;
        mov[p] = ok;
        if (ok) mow[p] = wd;
        for (int i = 0; i < NCH; i++) begin
            case (mst[p][i])
                0: if (drp[i]) mst[p][i] = 1;
                1: if (sd_r[i]) mst[p][i] = sp_r[i] ? 2 : 0;
                2: if (ra_r[i]) mst[p][i] = 0;
                default: mst[p][i] = 0;
            endcase
        end
    endtask

    task automatic compare(input int p, input string tag);
        logic dsf, dov; logic [W-1:0] dow; logic [NCH-1:0] drq, dmk;
        logic [2:0] dct; logic [7:0] dcs; int n;
        dsf = p ? sf1 : sf0; dov = p ? ov1 : ov0; dow = p ? ow1 : ow0;
        drq = p ? rq1 : rq0; dmk = p ? mk1 : mk0; dct = p ? ct1 : ct0;
        dcs = p ? cs1 : cs0;
        n = 0;
        for (int i = 0; i < NCH; i++) if (mst[p][i] == 0) n++;
        chk(dsf == msf[p], tag, p ? "dg safe_req" : "fs safe_req", int'(dsf), int'(msf[p]));
        chk(dov == mov[p], tag, p ? "dg out_valid" : "fs out_valid", int'(dov), int'(mov[p]));
        if (mov[p]) chk(dow == mow[p], tag, p ? "dg out_word" : "fs out_word", int'(dow), int'(mow[p]));
        chk(int'(dct) == n, tag, p ? "dg act_count" : "fs act_count", int'(dct), n);
        for (int i = 0; i < NCH; i++) begin
            chk(int'(dcs[2*i +: 2]) == mst[p][i], tag, "ch_status", int'(dcs[2*i +: 2]), mst[p][i]);
            chk(dmk[i] == (mst[p][i] == 0), tag, "act_mask", int'(dmk[i]), int'(mst[p][i] == 0));
            chk(drq[i] == (mst[p][i] == 1), tag, "st_req", int'(drq[i]), int'(mst[p][i] == 1));
        end
    endtask

    // Reference advances on every edge and is compared just after it
    always @(posedge clk) begin
        if (rst) model_reset();
        else begin
            model_step(0);
            model_step(1);
        end
        #1;
        if (armed) begin
            compare(0, cur_tag);
            compare(1, cur_tag);
        end
    end

    task automatic cyc(input bit iv, input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic [W-1:0] c, input logic [W-1:0] d,
                       input logic [3:0] e, input logic [3:0] sd,
                       input logic [3:0] sp, input logic [3:0] ra, input string tag);
        @(negedge clk);
        iv_r = iv; w_r[0] = a; w_r[1] = b; w_r[2] = c; w_r[3] = d;
        e_r = e; sd_r = sd; sp_r = sp; ra_r = ra; cur_tag = tag;
    endtask

    task automatic settle();
        @(posedge clk);
        #2;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; iv_r = 1'b0; e_r = '0; sd_r = '0; sp_r = '0; ra_r = '0;
        for (int i = 0; i < NCH; i++) w_r[i] = '0;
        cur_tag = "R3";
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < NCH; i++) w_r[i] = '0;
        do_reset();
        armed = 1'b1;
        settle();
        chk(ct0 == 3'd4 && ct1 == 3'd4, "R3", "reset count", int'(ct0), 4);
        chk(mk0 == 4'hF && !sf0 && !ov0, "R3", "reset mask", int'(mk0), 15);

        // Scenario 1: walk down the pool and back up
        cyc(1, 16'h1111, 16'h1111, 16'h1111, 16'h1111, 4'h0, 4'h0, 4'h0, 4'h0, "R1");
        settle();
        chk(ov0 && ow0 == 16'h1111, "R1", "unanimous word", int'(ow0), 'h1111);
        cyc(1, 16'h2222, 16'h2222, 16'h2222, 16'h9999, 4'h0, 4'h0, 4'h0, 4'h0, "R1");
        settle();
        chk(ow0 == 16'h2222 && mk0 == 4'b0111, "R1", "outvoted mask", int'(mk0), 7);
        chk(rq0 == 4'b1000, "R4", "test request", int'(rq0), 8);
        cyc(1, 16'h3333, 16'h3333, 16'h3333, 16'h0BAD, 4'h0, 4'h8, 4'h8, 4'h0, "R4");
        settle();
        chk(cs0[7:6] == 2'd2, "R4", "permanent parks", int'(cs0[7:6]), 2);
        cyc(1, 16'h4444, 16'h4444, 16'h5555, 16'h0, 4'h4, 4'h0, 4'h0, 4'h0, "R7");
        settle();
        chk(ov0 && ow0 == 16'h4444 && ct0 == 3'd2, "R7", "flagged dropped", int'(ct0), 2);
        cyc(0, 16'h6666, 16'h7777, 16'h0, 16'h0, 4'h2, 4'h0, 4'h0, 4'h0, "R11");
        settle();
        chk(!ov0 && ct0 == 3'd2 && ct1 == 3'd2, "R11", "idle keeps pool", int'(ct0), 2);
        cyc(1, 16'h7777, 16'h7777, 16'h0, 16'h0, 4'h0, 4'h0, 4'h0, 4'h0, "R2");
        settle();
        chk(ov0 && ow0 == 16'h7777, "R2", "pair match", int'(ow0), 'h7777);
        cyc(1, 16'h8888, 16'hDEAD, 16'h0, 16'h0, 4'h2, 4'h0, 4'h0, 4'h0, "R5 R6");
        settle();
        chk(sf0 == 1'b1 && !ov0, "R5", "failsafe local err", int'(sf0), 1);
        chk(!sf1 && ct1 == 3'd1 && ow1 == 16'h8888, "R6", "degrade continues", int'(ct1), 1);
        cyc(1, 16'hA0A0, 16'h0, 16'hFFFF, 16'h0, 4'h0, 4'h4, 4'h0, 4'h0, "R10");
        settle();
        chk(ov1 && ow1 == 16'hA0A0 && ct1 == 3'd2, "R10", "rejoin after vote", int'(ct1), 2);
        cyc(1, 16'hB0B0, 16'h0, 16'hB0B0, 16'h0, 4'h0, 4'h2, 4'h0, 4'h8, "R10");
        settle();
        chk(ov1 && ow1 == 16'hB0B0 && ct1 == 3'd4, "R4", "all back", int'(ct1), 4);
        cyc(1, 16'h0001, 16'h0002, 16'h0003, 16'h0003, 4'h0, 4'h0, 4'h0, 4'h0, "R9");
        settle();
        chk(sf1 && !ov1, "R9", "split four", int'(sf1), 1);
        cyc(1, 16'h1234, 16'h1234, 16'h1234, 16'h1234, 4'h0, 4'h0, 4'h0, 4'h0, "R8");
        settle();
        chk(sf0 && sf1 && !ov0 && !ov1, "R8", "sticky safe", int'(ov1), 0);

        // Scenario 2: flagged word must not tip the vote
        do_reset();
        cyc(1, 16'hCAFE, 16'hCAFE, 16'hCAFE, 16'hBEEF, 4'h1, 4'h0, 4'h0, 4'h0, "R7");
        settle();
        chk(sf0 && sf1, "R7", "flagged excluded", int'(sf0), 1);

        // Scenario 3: pair mismatch under both policies
        do_reset();
        cyc(1, 16'h1, 16'h1, 16'h1, 16'h2, 4'h0, 4'h0, 4'h0, 4'h0, "R3");
        cyc(1, 16'h1, 16'h1, 16'h2, 16'h2, 4'h0, 4'h0, 4'h0, 4'h0, "R3");
        cyc(1, 16'h5, 16'h6, 16'h5, 16'h5, 4'h0, 4'h0, 4'h0, 4'h0, "R2 R6");
        settle();
        chk(sf0 && sf1, "R2", "pair mismatch", int'(sf1), 1);

        // Scenario 4: last channel flags an error
        do_reset();
        cyc(1, 16'h1, 16'h1, 16'h1, 16'h2, 4'h0, 4'h0, 4'h0, 4'h0, "R3");
        cyc(1, 16'h1, 16'h1, 16'h2, 16'h2, 4'h0, 4'h0, 4'h0, 4'h0, "R3");
        cyc(1, 16'h1, 16'h1, 16'h0, 16'h0, 4'h2, 4'h0, 4'h0, 4'h0, "R6");
        cyc(1, 16'h1, 16'h1, 16'h0, 16'h0, 4'h1, 4'h0, 4'h0, 4'h0, "R12");
        settle();
        chk(sf1 && ct1 == 3'd1, "R12", "solo error", int'(ct1), 1);

        // Scenario 5: three distinct words
        do_reset();
        cyc(1, 16'h1, 16'h1, 16'h1, 16'h2, 4'h0, 4'h0, 4'h0, 4'h0, "R3");
        cyc(1, 16'h7, 16'h8, 16'h9, 16'h7, 4'h0, 4'h0, 4'h0, 4'h0, "R9");
        settle();
        chk(sf0 && sf1, "R9", "no majority", int'(sf0), 1);

        // Random phase against the reference
        for (int k = 0; k < 3000; k++) begin
            logic [W-1:0] base;
            logic [W-1:0] ws [NCH];
            logic [3:0] e, sd, sp, ra;
            if (k % 300 == 0) do_reset();
            base = W'($urandom);
            for (int i = 0; i < NCH; i++)
                ws[i] = ($urandom % 8 == 0) ? W'($urandom % 4) : base;
            for (int i = 0; i < NCH; i++) begin
                e[i]  = ($urandom % 16 == 0);
                sd[i] = ($urandom % 4 == 0);
                sp[i] = ($urandom % 2 == 0);
                ra[i] = ($urandom % 8 == 0);
            end
            cyc(($urandom % 8) != 0, ws[0], ws[1], ws[2], ws[3], e, sd, sp, ra, "R3");
        end

        settle();
        summary();
        $finish;
    end

endmodule